// File: doc/BRIEF.md
# GPIO Bank Controller with Pad Loopback

This block controls one bank of general-purpose pins through four word registers on a simple register bus. One register holds the output levels. One holds a direction bit for each pin. One reports the sampled pad levels and cannot be written. The last holds an input-enable (loopback) bit for each pin. The output levels and the output enables go straight to the pad drivers. The incoming pad levels pass through a synchroniser before the block uses them.

Reading the output-level register gives a view that depends on the pin's mode. An output pin returns its stored bit. An input pin returns its sampled pad level. The pad status register shows the real pad level for every input pin. For an output pin it shows the pad level only when that pin's loopback bit is set, so software can detect a pin that another driver on the board is fighting. A pin with loopback clear in output mode reads 0. The usual way to bring up an output is to set loopback if read-back is wanted, then set the direction bit, then write the level. A level may also be written before the pin becomes an output.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the level, direction and loopback registers are 0, so every pin is an input and both pad_out and pad_oe are 0.
- R2: A direction bit of 1 makes its pin an output and a bit of 0 makes it an input. The direction register sits at byte offset 0x4, reads back what was written, and drives pad_oe.
- R3: pad_out always carries the stored level register (offset 0x0). An output pin therefore drives its stored bit.
- R4: A read of offset 0x0 returns the stored bit for each output pin and the synchronised pad level for each input pin.
- R5: A read of the pad status register (offset 0x8) returns the synchronised pad level for every input pin.
- R6: For an output pin whose loopback bit (offset 0xC) is 1, the status bit equals the synchronised pad level. Without contention this is the driven bit; under contention it is the real pad level.
- R7: For an output pin whose loopback bit is 0, the status bit reads 0.
- R8: A change on pad_in shows up in the status register after exactly two rising clock edges, and not after one.
- R9: Writes to offset 0x0 are stored whatever the direction bits are, so a level written while a pin is an input is driven once the pin becomes an output.
- R10: Writes to offset 0x8 have no effect on any register.
- R11: The loopback register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: byte offset bits 3:2 (0 level, 1 direction, 2 pad status, 3 loopback) |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for the selected register, combinational from bus_addr |
| pad_in | input | NUM_PINS | Pad levels, asynchronous to clk |
| pad_out | output | NUM_PINS | Level driven to the pad drivers |
| pad_oe | output | NUM_PINS | Output enable to the pad drivers, 1 per output pin |

## Verification
The clocked properties assume that bus_addr, bus_wr and bus_wdata are stable around each rising edge. The stage-shift property also assumes that reset is held for at least one full clock, which clears every synchroniser stage before any comparison with the past is made. The bench changes every bus input and pad_in only on falling edges. It holds reset for several cycles at the start and again later in the run. Each read is taken after the pad value has had at least two clock edges to settle, except in the latency test, which deliberately samples after one edge and again after two.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register selects, taken from byte-offset bits 3:2
    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'd0,
        SEL_DIR    = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_LPBK   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr_en;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic [1:0] word_idx, input logic wr);
        bus_cmd_t c;
        c.wr_en = wr;
        c.sel   = reg_sel_e'(word_idx);
        return c;
    endfunction

    function automatic logic sel_writable(input reg_sel_e s);
        return s != SEL_STATUS;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_async,
    output logic [WIDTH-1:0] pad_synced
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= pad_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
                // R8
                stage_shift_chk: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> stage_q[s] == $past(stage_q[s-1]));
            end
        end
    endgenerate

    assign pad_synced = stage_q[LAST];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lpbk_q
);
    logic do_write;
    assign do_write = cmd.wr_en && sel_writable(cmd.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            dir_q   <= '0;
            lpbk_q  <= '0;
        end else if (do_write) begin
            case (cmd.sel)
                SEL_LEVEL: level_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_LPBK:  lpbk_q  <= wdata;
                default:   ;
            endcase
        end
    end

    // R9
    level_write_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_LEVEL) |=> level_q == $past(wdata));

    // R10
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_STATUS) |=>
            ($stable(level_q) && $stable(dir_q) && $stable(lpbk_q)));

    // R11
    lpbk_write_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_LPBK) |=> lpbk_q == $past(wdata));

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] level_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lpbk_q,
    input  logic [WIDTH-1:0] pad_synced,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] in_buf_en;
    logic [WIDTH-1:0] status_view;
    logic [WIDTH-1:0] level_view;

    // The input buffer is live for input pins, and for output pins with loopback
    assign in_buf_en   = ~dir_q | lpbk_q;
    assign status_view = pad_synced & in_buf_en;
    assign level_view  = (dir_q & level_q) | (~dir_q & status_view);

    always_comb begin
        case (sel)
            SEL_LEVEL:  rdata = level_view;
            SEL_DIR:    rdata = dir_q;
            SEL_STATUS: rdata = status_view;
            SEL_LPBK:   rdata = lpbk_q;
            default:    rdata = '0;
        endcase
    end

    // R4
    level_read_output_chk: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_LEVEL |-> ((rdata ^ level_q) & dir_q) == '0);

    // R5
    status_read_input_chk: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_STATUS |-> ((rdata ^ pad_synced) & ~dir_q) == '0);

    // R7
    status_masked_chk: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_STATUS |-> (rdata & dir_q & ~lpbk_q) == '0);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:2]          bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    bus_cmd_t            cmd;
    logic [NUM_PINS-1:0] level_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] lpbk_q;
    logic [NUM_PINS-1:0] pad_synced;

    assign cmd = decode_cmd(bus_addr, bus_wr);

    gpio_ctrl_regs #(.WIDTH(NUM_PINS)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (bus_wdata),
        .level_q (level_q),
        .dir_q   (dir_q),
        .lpbk_q  (lpbk_q)
    );

    gpio_pad_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .pad_async  (pad_in),
        .pad_synced (pad_synced)
    );

    gpio_readback #(.WIDTH(NUM_PINS)) rb_i (
        .clk        (clk),
        .rst        (rst),
        .sel        (cmd.sel),
        .level_q    (level_q),
        .dir_q      (dir_q),
        .lpbk_q     (lpbk_q),
        .pad_synced (pad_synced),
        .rdata      (bus_rdata)
    );

    assign pad_out = level_q;
    assign pad_oe  = dir_q;

    // R2
    dir_drives_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> pad_oe == $past(bus_wdata));

    // R3
    level_drives_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> pad_out == $past(bus_wdata));

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;

    localparam logic [1:0] A_LEVEL  = 2'd0;
    localparam logic [1:0] A_DIR    = 2'd1;
    localparam logic [1:0] A_STATUS = 2'd2;
    localparam logic [1:0] A_LPBK   = 2'd3;

    typedef struct packed {
        logic [1:0]  wa;
        logic [31:0] wd;
        logic [31:0] pad;
        logic [1:0]  ra;
        logic [31:0] exp_rd;
        logic [31:0] exp_out;
        logic [31:0] exp_oe;
    } vec_t;

    // Each row: set pad, write (wa, wd), let the pad settle, read ra
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // R2: low half becomes output
        '{A_DIR,    32'h0000_FFFF, 32'hA5A5_A5A5, A_DIR,    32'h0000_FFFF, 32'h0000_0000, 32'h0000_FFFF},
        // R4: outputs give the stored bits, inputs give the pad
        '{A_LEVEL,  32'h1234_5678, 32'hA5A5_A5A5, A_LEVEL,  32'hA5A5_5678, 32'h1234_5678, 32'h0000_FFFF},
        // R5 R6 R7: loopback on bits 7:0 only
        '{A_LPBK,   32'h0000_00FF, 32'hA5A5_A5A5, A_STATUS, 32'hA5A5_00A5, 32'h1234_5678, 32'h0000_FFFF},
        // R10: status write dropped
        '{A_STATUS, 32'hFFFF_FFFF, 32'h0F0F_0F0F, A_STATUS, 32'h0F0F_000F, 32'h1234_5678, 32'h0000_FFFF},
        // R9: upper half preloaded while input, now driven
        '{A_DIR,    32'hFFFF_0000, 32'h0F0F_0F0F, A_LEVEL,  32'h1234_0F0F, 32'h1234_5678, 32'hFFFF_0000},
        // R6: loopback everywhere, no contention
        '{A_LPBK,   32'hFFFF_FFFF, 32'h1234_0000, A_STATUS, 32'h1234_0000, 32'h1234_5678, 32'hFFFF_0000},
        // R11 R3
        '{A_LEVEL,  32'hFFFF_AAAA, 32'h1234_5555, A_LPBK,   32'hFFFF_FFFF, 32'hFFFF_AAAA, 32'hFFFF_0000},
        // R6: contention on the upper half shows the real pad
        '{A_DIR,    32'hFFFF_FFFF, 32'h0000_5555, A_STATUS, 32'h0000_5555, 32'hFFFF_AAAA, 32'hFFFF_FFFF},
        // R4: all outputs read stored bits despite contention
        '{A_LPBK,   32'h0000_0000, 32'h0000_5555, A_LEVEL,  32'hFFFF_AAAA, 32'hFFFF_AAAA, 32'hFFFF_FFFF},
        // R7 R10: outputs without loopback read 0
        '{A_STATUS, 32'h1234_5678, 32'h0000_5555, A_STATUS, 32'h0000_0000, 32'hFFFF_AAAA, 32'hFFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        bus_read(A_LEVEL, rd);  check("R1 level", rd, 32'h0);
        bus_read(A_DIR, rd);    check("R1 dir", rd, 32'h0);
        bus_read(A_LPBK, rd);   check("R1 lpbk", rd, 32'h0);
        bus_read(A_STATUS, rd); check("R1 status", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            pad_in = VECS[i].pad;
            bus_write(VECS[i].wa, VECS[i].wd);
            repeat (2) @(negedge clk);
            bus_read(VECS[i].ra, rd);
            check($sformatf("vector %0d read", i), rd, VECS[i].exp_rd);
            check($sformatf("vector %0d R3 pad_out", i), pad_out, VECS[i].exp_out);
            check($sformatf("vector %0d R2 pad_oe", i), pad_oe, VECS[i].exp_oe);
        end

        // R8: two-edge latency into the status register
        pad_in = 32'h0;
        bus_write(A_DIR, 32'h0);
        repeat (3) @(negedge clk);
        bus_addr = A_STATUS;
        pad_in   = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_read(A_STATUS, rd); check("R8 after one edge", rd, 32'h0);
        @(negedge clk);
        bus_read(A_STATUS, rd); check("R8 after two edges", rd, 32'hDEAD_BEEF);
        // R5: all inputs follow the pad
        bus_read(A_LEVEL, rd);  check("R5 R4 inputs in level view", rd, 32'hDEAD_BEEF);

        // R1: reset in mid-run clears the registers
        bus_write(A_DIR, 32'h00FF_00FF);
        bus_write(A_LPBK, 32'h0F0F_0F0F);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 pad_out after reset", pad_out, 32'h0);
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        bus_read(A_LPBK, rd); check("R1 lpbk after reset", rd, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule